// File: doc/BRIEF.md
# Power Controller Protection Supervisor

This block is the digital fault supervisor of a combined power-factor-correction and flyback controller. Analog comparators outside the block turn supply, feedback, line, temperature and output-sense levels into single-bit flags. The supervisor filters each flag over time and chooses a shutdown class for each fault. It then decides whether the power-factor stage and the flyback stage may switch.

Faults fall into two classes. Supply over-voltage, output over-voltage and the temperature or external-trigger level on the thermistor input are latching faults. Once latched, they hold every gate off until a power-removal input clears them. Open-loop feedback and a collapsed PFC output sense are auto-recovery faults. They stop switching until the supply has dropped through its off level and has come back up through its turn-on level. A line brownout is remembered, and it blocks any restart until the line is back above its higher re-arm level. Inside normal operation, the PFC stage is also gated by load level. Each direction of that gating has its own debounce window.

All debounce lengths are parameters counted in clock cycles. The defaults assume a 1 MHz clock.

Top module: `psup_top`

## Requirements
- R1: While `rstN` is low, and right after it is released with all flags low, `pfcEn`, `pwmEn`, `faultLatched`, `hiccup` and `brownout` are all 0.
- R2: From the off state, `vddOnLvl` high with `vddPwmOffLvl` low and no pending brownout raises `pwmEn` and `pfcEn` on the first clock edge.
- R3: While running, `vddPwmOffLvl` high drops both enables on the next edge and enters the off state. A later `vddOnLvl` restarts switching.
- R4: `vddOvLvl` held for VDD_OVP_CYC consecutive edges sets `faultLatched` on that edge and clears both enables. One edge fewer has no effect.
- R5: `detOvLvl` held for DET_OVP_CYC consecutive edges latches the same way.
- R6: `rtLatchLvl` held for RT_SLOW_CYC edges latches. If `rtFastLvl` is also high, the latch occurs once `rtLatchLvl` has been high for RT_FAST_CYC edges, counting edges from before `rtFastLvl` rose.
- R7: `faultLatched` stays set through any supply activity. It clears only when `pwrRemoved` is high, which returns the block to the off state.
- R8: `fbOpenLvl` held for FB_OLP_CYC edges while running stops both stages and sets `hiccup`. Switching resumes, and `hiccup` clears, only after `vddPwmOffLvl` and then `vddOnLvl`.
- R9: `invLowLvl` while running stops both stages on the very next edge and sets `hiccup`. The restart follows the same cycle as R8.
- R10: `vinLowLvl` held for VIN_BO_CYC edges sets `brownout` without stopping switching. While `brownout` is set, a turn-on succeeds only if `vinRearmLvl` is high, and that turn-on clears `brownout`.
- R11: While running, `fbPfcOffLvl` held for PFC_OFF_CYC edges clears `pfcEn` and leaves `pwmEn` high. `fbPfcOnLvl` held for PFC_ON_CYC edges sets `pfcEn` again. Neither count advances outside the running state.
- R12: Every debounce count restarts from zero when its flag goes low before the count completes.
- R13: `pwrRemoved` overrides every other input. A latching fault overrides an auto-recovery fault, including one already in hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrRemoved | input | 1 | Power removed; clears a latched fault |
| vddOnLvl | input | 1 | Supply above turn-on level |
| vddPwmOffLvl | input | 1 | Supply below switching-off level |
| vddOvLvl | input | 1 | Supply over-voltage |
| detOvLvl | input | 1 | Sampled output-sense level over-voltage |
| rtLatchLvl | input | 1 | Thermistor pin below latch level |
| rtFastLvl | input | 1 | Thermistor pin below fast-debounce level |
| fbOpenLvl | input | 1 | Feedback above open-loop level |
| vinLowLvl | input | 1 | Line sense below brownout level |
| vinRearmLvl | input | 1 | Line sense above re-arm level |
| invLowLvl | input | 1 | PFC output sense below brownout stop level |
| fbPfcOffLvl | input | 1 | Feedback below PFC-off level |
| fbPfcOnLvl | input | 1 | Feedback above PFC-on level |
| pfcEn | output | 1 | PFC stage may switch |
| pwmEn | output | 1 | Flyback stage may switch |
| faultLatched | output | 1 | A latching fault is held |
| hiccup | output | 1 | Auto-recovery fault, waiting for a supply cycle |
| brownout | output | 1 | Line brownout remembered |

## Verification
Single flags are held for exactly one edge less than their window and then for the full window. This separates a correct count length from an off-by-one. A flag that is dropped for one edge and then raised again shows whether the count restarts or only pauses. The thermistor flags are driven alone, together, and with the fast flag arriving after the slow count has already passed the short window; these three cases tell the two debounce lengths apart. Supply sequences that differ only in ordering show the difference between latch, hiccup, plain undervoltage-off and brownout-blocked restart. Flags that arrive together show which fault class takes priority.

// File: rtl/psup_pkg.sv
package psup_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_HIC_DROP,
    ST_HIC_REARM,
    ST_LATCH
  } supState_t;

  // control -> datapath: counter clear strobes
  typedef struct packed {
    logic olpClr;
    logic loadClr;
  } cntCtl_t;

  // datapath -> control: debounced trips
  typedef struct packed {
    logic vddOv;
    logic detOv;
    logic rtTrip;
    logic olp;
    logic vinLow;
    logic pfcOff;
    logic pfcOn;
  } trip_t;

  localparam int NUM_DEB = 6;
  localparam int IDX_VDDOV  = 0;
  localparam int IDX_DETOV  = 1;
  localparam int IDX_OLP    = 2;
  localparam int IDX_VINLOW = 3;
  localparam int IDX_PFCOFF = 4;
  localparam int IDX_PFCON  = 5;

endpackage

// File: rtl/psup_debounce.sv
module psup_debounce #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic flag,
  input  logic clr,
  output logic done
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (clr || !flag)   cnt <= '0;
    else if (cnt != TOP)     cnt <= cnt + 1'b1;
  end

  assign done = flag && (cnt == TOP);

  // R12: a completed count always needs the flag on the previous edge too
  a_r12_done_needs_history: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(flag));
  // R12: a low flag restarts the count, so no trip can follow directly
  a_r12_low_restarts: assert property (@(posedge clk) disable iff (!rstN)
    !flag |=> !done);

endmodule

// File: rtl/psup_datapath.sv
module psup_datapath
  import psup_pkg::*;
#(
  parameter int VDD_OVP_CYC = 150,
  parameter int DET_OVP_CYC = 150,
  parameter int RT_FAST_CYC = 110,
  parameter int RT_SLOW_CYC = 10000,
  parameter int FB_OLP_CYC  = 50000,
  parameter int VIN_BO_CYC  = 100000,
  parameter int PFC_OFF_CYC = 500000,
  parameter int PFC_ON_CYC  = 2500
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    vddOvLvl,
  input  logic    detOvLvl,
  input  logic    rtLatchLvl,
  input  logic    rtFastLvl,
  input  logic    fbOpenLvl,
  input  logic    vinLowLvl,
  input  logic    fbPfcOffLvl,
  input  logic    fbPfcOnLvl,
  input  cntCtl_t ctl,
  output trip_t   trip
);
  localparam int LIM [NUM_DEB] = '{VDD_OVP_CYC, DET_OVP_CYC, FB_OLP_CYC,
                                   VIN_BO_CYC, PFC_OFF_CYC, PFC_ON_CYC};
  localparam int RCW = $clog2(RT_SLOW_CYC);
  localparam logic [RCW-1:0] RT_TOP  = RCW'(RT_SLOW_CYC - 1);
  localparam logic [RCW-1:0] RT_FTOP = RCW'(RT_FAST_CYC - 1);

  logic [NUM_DEB-1:0] flagVec, clrVec, doneVec;

  always_comb begin
    flagVec = '0;
    flagVec[IDX_VDDOV]  = vddOvLvl;
    flagVec[IDX_DETOV]  = detOvLvl;
    flagVec[IDX_OLP]    = fbOpenLvl;
    flagVec[IDX_VINLOW] = vinLowLvl;
    flagVec[IDX_PFCOFF] = fbPfcOffLvl;
    flagVec[IDX_PFCON]  = fbPfcOnLvl;
    clrVec = '0;
    clrVec[IDX_OLP]     = ctl.olpClr;
    clrVec[IDX_PFCOFF]  = ctl.loadClr;
    clrVec[IDX_PFCON]   = ctl.loadClr;
  end

  for (genvar g = 0; g < NUM_DEB; g++) begin : g_deb
    psup_debounce #(.LIMIT(LIM[g])) deb_i (
      .clk  (clk),
      .rstN (rstN),
      .flag (flagVec[g]),
      .clr  (clrVec[g]),
      .done (doneVec[g])
    );
  end

  // two-window thermistor filter: one counter, two compare points
  logic [RCW-1:0] rtCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              rtCnt <= '0;
    else if (!rtLatchLvl)   rtCnt <= '0;
    else if (rtCnt != RT_TOP) rtCnt <= rtCnt + 1'b1;
  end

  always_comb begin
    trip.vddOv  = doneVec[IDX_VDDOV];
    trip.detOv  = doneVec[IDX_DETOV];
    trip.olp    = doneVec[IDX_OLP];
    trip.vinLow = doneVec[IDX_VINLOW];
    trip.pfcOff = doneVec[IDX_PFCOFF];
    trip.pfcOn  = doneVec[IDX_PFCON];
    trip.rtTrip = rtLatchLvl && ((rtCnt == RT_TOP) || (rtFastLvl && rtCnt >= RT_FTOP));
  end

  // R6: the thermistor trip needs the latch level on this and the previous edge
  a_r6_rt_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    trip.rtTrip |-> rtLatchLvl && $past(rtLatchLvl));

endmodule

// File: rtl/psup_control.sv
module psup_control
  import psup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrRemoved,
  input  logic    vddOnLvl,
  input  logic    vddPwmOffLvl,
  input  logic    invLowLvl,
  input  logic    vinRearmLvl,
  input  trip_t   trip,
  output cntCtl_t ctl,
  output logic    pfcEn,
  output logic    pwmEn,
  output logic    faultLatched,
  output logic    hiccup,
  output logic    brownout
);
  supState_t state, stateNxt;
  logic loadOk, brownReg;
  logic latchHit, restartOk;

  assign latchHit  = trip.vddOv || trip.detOv || trip.rtTrip;
  assign restartOk = vddOnLvl && !vddPwmOffLvl && (!brownReg || vinRearmLvl);

  always_comb begin
    stateNxt = state;
    if (pwrRemoved)    stateNxt = ST_OFF;
    else if (latchHit) stateNxt = ST_LATCH;
    else begin
      case (state)
        ST_OFF:       if (restartOk) stateNxt = ST_RUN;
        ST_RUN: begin
          if (invLowLvl || trip.olp) stateNxt = ST_HIC_DROP;
          else if (vddPwmOffLvl)     stateNxt = ST_OFF;
        end
        ST_HIC_DROP:  if (vddPwmOffLvl) stateNxt = ST_HIC_REARM;
        ST_HIC_REARM: if (restartOk)    stateNxt = ST_RUN;
        ST_LATCH:     stateNxt = ST_LATCH;
        default:      stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_OFF;
      loadOk   <= 1'b1;
      brownReg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state != ST_RUN)            loadOk <= 1'b1;
      else if (loadOk && trip.pfcOff) loadOk <= 1'b0;
      else if (!loadOk && trip.pfcOn) loadOk <= 1'b1;
      if (pwrRemoved)       brownReg <= 1'b0;
      else if (trip.vinLow) brownReg <= 1'b1;
      else if (state != ST_RUN && stateNxt == ST_RUN) brownReg <= 1'b0;
    end
  end

  always_comb begin
    ctl.olpClr  = (state != ST_RUN);
    ctl.loadClr = (state != ST_RUN) || (loadOk ? trip.pfcOff : trip.pfcOn);
  end

  assign pwmEn        = (state == ST_RUN);
  assign pfcEn        = (state == ST_RUN) && loadOk;
  assign faultLatched = (state == ST_LATCH);
  assign hiccup       = (state == ST_HIC_DROP) || (state == ST_HIC_REARM);
  assign brownout     = brownReg;

  // R7: a latch survives everything except power removal
  a_r7_latch_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched && !pwrRemoved |=> faultLatched);
  // R7: no gate runs while latched
  a_r7_latch_silent: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> !pwmEn && !pfcEn);
  // R11: the PFC stage never runs without the flyback stage
  a_r11_pfc_needs_pwm: assert property (@(posedge clk) disable iff (!rstN)
    pfcEn |-> pwmEn);
  // R9: low PFC output sense stops switching on the next edge
  a_r9_inv_stops: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn && invLowLvl |=> !pwmEn);
  // R10: no restart while brownout is held and the line is not re-armed
  a_r10_restart_gated: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn && brownout && !vinRearmLvl |=> !pwmEn);
  // R13: power removal wins over everything
  a_r13_power_removal: assert property (@(posedge clk) disable iff (!rstN)
    pwrRemoved |=> !faultLatched && !pwmEn && !hiccup);

endmodule

// File: rtl/psup_top.sv
module psup_top
  import psup_pkg::*;
#(
  parameter int VDD_OVP_CYC = 150,
  parameter int DET_OVP_CYC = 150,
  parameter int RT_FAST_CYC = 110,
  parameter int RT_SLOW_CYC = 10000,
  parameter int FB_OLP_CYC  = 50000,
  parameter int VIN_BO_CYC  = 100000,
  parameter int PFC_OFF_CYC = 500000,
  parameter int PFC_ON_CYC  = 2500
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrRemoved,
  input  logic vddOnLvl,
  input  logic vddPwmOffLvl,
  input  logic vddOvLvl,
  input  logic detOvLvl,
  input  logic rtLatchLvl,
  input  logic rtFastLvl,
  input  logic fbOpenLvl,
  input  logic vinLowLvl,
  input  logic vinRearmLvl,
  input  logic invLowLvl,
  input  logic fbPfcOffLvl,
  input  logic fbPfcOnLvl,
  output logic pfcEn,
  output logic pwmEn,
  output logic faultLatched,
  output logic hiccup,
  output logic brownout
);
  cntCtl_t ctl;
  trip_t   trip;

  psup_datapath #(
    .VDD_OVP_CYC (VDD_OVP_CYC), .DET_OVP_CYC (DET_OVP_CYC),
    .RT_FAST_CYC (RT_FAST_CYC), .RT_SLOW_CYC (RT_SLOW_CYC),
    .FB_OLP_CYC  (FB_OLP_CYC),  .VIN_BO_CYC  (VIN_BO_CYC),
    .PFC_OFF_CYC (PFC_OFF_CYC), .PFC_ON_CYC  (PFC_ON_CYC)
  ) dp_i (
    .clk (clk), .rstN (rstN),
    .vddOvLvl (vddOvLvl), .detOvLvl (detOvLvl),
    .rtLatchLvl (rtLatchLvl), .rtFastLvl (rtFastLvl),
    .fbOpenLvl (fbOpenLvl), .vinLowLvl (vinLowLvl),
    .fbPfcOffLvl (fbPfcOffLvl), .fbPfcOnLvl (fbPfcOnLvl),
    .ctl (ctl), .trip (trip)
  );

  psup_control ctrl_i (
    .clk (clk), .rstN (rstN),
    .pwrRemoved (pwrRemoved), .vddOnLvl (vddOnLvl),
    .vddPwmOffLvl (vddPwmOffLvl), .invLowLvl (invLowLvl),
    .vinRearmLvl (vinRearmLvl), .trip (trip), .ctl (ctl),
    .pfcEn (pfcEn), .pwmEn (pwmEn), .faultLatched (faultLatched),
    .hiccup (hiccup), .brownout (brownout)
  );

endmodule

// File: tb/psup_top_tb_top.sv
`timescale 1ns/1ps
module psup_top_tb_top;

  // stimulus bit positions
  localparam logic [12:0] I_ON  = 13'h0001, I_POFF_V = 13'h0002, I_VOV = 13'h0004,
                          I_DOV = 13'h0008, I_RTL = 13'h0010, I_RTF = 13'h0020,
                          I_OLP = 13'h0040, I_VIN = 13'h0080, I_REARM = 13'h0100,
                          I_INV = 13'h0200, I_POFF = 13'h0400, I_PON = 13'h0800,
                          I_PWR = 13'h1000;
  // expected {pfcEn, pwmEn, faultLatched, hiccup, brownout}
  localparam logic [4:0] X_OFF = 5'b00000, X_RUN = 5'b11000, X_PWM = 5'b01000,
                         X_LAT = 5'b00100, X_HIC = 5'b00010, X_BRO = 5'b00001;

  typedef struct packed {
    logic [12:0] stim;
    logic [7:0]  hold;
    logic [4:0]  exp;
    logic [4:0]  req;
  } row_t;

  localparam int NROW = 50;
  localparam row_t TBL [NROW] = '{
    '{13'h0,           8'd2,  X_OFF,       5'd1},   // R1
    '{I_ON,            8'd1,  X_RUN,       5'd2},   // R2
    '{I_ON,            8'd3,  X_RUN,       5'd2},
    '{I_ON|I_POFF,     8'd39, X_RUN,       5'd11},  // R11 one short
    '{I_ON|I_POFF,     8'd1,  X_PWM,       5'd11},
    '{I_ON|I_PON,      8'd5,  X_PWM,       5'd11},
    '{I_ON|I_PON,      8'd1,  X_RUN,       5'd11},
    '{I_ON|I_OLP,      8'd19, X_RUN,       5'd8},   // R8
    '{I_ON,            8'd1,  X_RUN,       5'd12},  // R12 gap
    '{I_ON|I_OLP,      8'd19, X_RUN,       5'd12},
    '{I_ON|I_OLP,      8'd1,  X_HIC,       5'd8},
    '{I_ON,            8'd3,  X_HIC,       5'd8},
    '{I_POFF_V,        8'd2,  X_HIC,       5'd8},
    '{I_ON,            8'd1,  X_RUN,       5'd8},
    '{I_ON|I_INV,      8'd1,  X_HIC,       5'd9},   // R9
    '{I_POFF_V,        8'd1,  X_HIC,       5'd9},
    '{I_ON,            8'd1,  X_RUN,       5'd9},
    '{I_ON|I_VIN,      8'd15, X_RUN,       5'd10},  // R10
    '{I_ON|I_VIN,      8'd1,  X_RUN|X_BRO, 5'd10},
    '{I_ON,            8'd1,  X_RUN|X_BRO, 5'd10},
    '{I_POFF_V,        8'd1,  X_BRO,       5'd3},   // R3
    '{I_ON,            8'd3,  X_BRO,       5'd10},
    '{I_ON|I_REARM,    8'd1,  X_RUN,       5'd10},
    '{I_ON|I_VOV,      8'd7,  X_RUN,       5'd4},   // R4
    '{I_ON,            8'd1,  X_RUN,       5'd12},
    '{I_ON|I_VOV,      8'd7,  X_RUN,       5'd4},
    '{I_ON|I_VOV,      8'd1,  X_LAT,       5'd4},
    '{I_POFF_V,        8'd3,  X_LAT,       5'd7},   // R7
    '{I_ON,            8'd3,  X_LAT,       5'd7},
    '{I_PWR,           8'd1,  X_OFF,       5'd7},
    '{I_ON,            8'd1,  X_RUN,       5'd2},
    '{I_ON|I_DOV,      8'd7,  X_RUN,       5'd5},   // R5
    '{I_ON|I_DOV,      8'd1,  X_LAT,       5'd5},
    '{I_PWR,           8'd1,  X_OFF,       5'd7},
    '{I_ON,            8'd1,  X_RUN,       5'd2},
    '{I_ON|I_RTL,      8'd29, X_RUN,       5'd6},   // R6 slow
    '{I_ON|I_RTL,      8'd1,  X_LAT,       5'd6},
    '{I_PWR,           8'd1,  X_OFF,       5'd7},
    '{I_ON,            8'd1,  X_RUN,       5'd2},
    '{I_ON|I_RTL|I_RTF, 8'd3, X_RUN,       5'd6},   // R6 fast
    '{I_ON|I_RTL|I_RTF, 8'd1, X_LAT,       5'd6},
    '{I_ON|I_RTL|I_RTF|I_OLP|I_INV, 8'd1, X_LAT, 5'd13}, // R13
    '{I_ON|I_PWR,      8'd1,  X_OFF,       5'd13},
    '{I_ON,            8'd1,  X_RUN,       5'd2},
    '{I_ON|I_INV|I_VOV, 8'd1, X_HIC,       5'd9},
    '{I_ON|I_INV|I_VOV, 8'd7, X_LAT,       5'd13},
    '{I_PWR,           8'd1,  X_OFF,       5'd7},
    '{I_ON,            8'd1,  X_RUN,       5'd3},
    '{I_POFF_V,        8'd1,  X_OFF,       5'd3},
    '{I_ON,            8'd1,  X_RUN,       5'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrRemoved, vddOnLvl, vddPwmOffLvl, vddOvLvl, detOvLvl, rtLatchLvl, rtFastLvl;
  logic fbOpenLvl, vinLowLvl, vinRearmLvl, invLowLvl, fbPfcOffLvl, fbPfcOnLvl;
  logic pfcEn, pwmEn, faultLatched, hiccup, brownout;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  psup_top #(
    .VDD_OVP_CYC (8), .DET_OVP_CYC (8), .RT_FAST_CYC (4), .RT_SLOW_CYC (30),
    .FB_OLP_CYC (20), .VIN_BO_CYC (16), .PFC_OFF_CYC (40), .PFC_ON_CYC (6)
  ) dut_i (
    .clk (clk), .rstN (rstN), .pwrRemoved (pwrRemoved), .vddOnLvl (vddOnLvl),
    .vddPwmOffLvl (vddPwmOffLvl), .vddOvLvl (vddOvLvl), .detOvLvl (detOvLvl),
    .rtLatchLvl (rtLatchLvl), .rtFastLvl (rtFastLvl), .fbOpenLvl (fbOpenLvl),
    .vinLowLvl (vinLowLvl), .vinRearmLvl (vinRearmLvl), .invLowLvl (invLowLvl),
    .fbPfcOffLvl (fbPfcOffLvl), .fbPfcOnLvl (fbPfcOnLvl),
    .pfcEn (pfcEn), .pwmEn (pwmEn), .faultLatched (faultLatched),
    .hiccup (hiccup), .brownout (brownout)
  );

  task automatic drive(input logic [12:0] s);
    vddOnLvl     = s[0];  vddPwmOffLvl = s[1];  vddOvLvl    = s[2];
    detOvLvl     = s[3];  rtLatchLvl   = s[4];  rtFastLvl   = s[5];
    fbOpenLvl    = s[6];  vinLowLvl    = s[7];  vinRearmLvl = s[8];
    invLowLvl    = s[9];  fbPfcOffLvl  = s[10]; fbPfcOnLvl  = s[11];
    pwrRemoved   = s[12];
  endtask

  // drive at a falling edge, let n rising edges pass, sample at the next falling edge
  task automatic step(input logic [12:0] s, input int n);
    drive(s);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {pfcEn, pwmEn, faultLatched, hiccup, brownout};
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: outputs {pfc,pwm,lat,hic,bro} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      summary();
    end
  end

  initial begin
    drive(13'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(X_OFF, "R1 in reset");
    rstN = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].stim, int'(TBL[i].hold));
      check(TBL[i].exp, $sformatf("R%0d table row %0d", TBL[i].req, i));
    end

    // R6 corner: fast level joins after the slow count passed the short window
    step(I_ON|I_RTL, 10);
    check(X_RUN, "R6 slow count running");
    step(I_ON|I_RTL|I_RTF, 1);
    check(X_LAT, "R6 fast level late");
    step(I_PWR, 1);
    check(X_OFF, "R7 power removal");

    // R11 corner: PFC-off level seen while off must not carry into run
    step(I_POFF, 50);
    check(X_OFF, "R11 off state idle");
    step(I_ON|I_POFF, 1);
    check(X_RUN, "R11 count cleared outside run");
    step(I_ON|I_POFF, 39);
    check(X_RUN, "R11 fresh window one short");
    step(I_ON|I_POFF, 1);
    check(X_PWM, "R11 fresh window full");

    // R1: reset while running
    drive(I_ON);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(X_OFF, "R1 reset mid-run");
    drive(13'h0);
    rstN = 1'b1;
    step(13'h0, 1);
    check(X_OFF, "R1 after release");

    finished = 1'b1;
    summary();
  end

endmodule